// File: doc/BRIEF.md
# Byte Program-and-Verify Sequencer

This block sits on the host side of an external byte-wide flash and programs a contiguous range of bytes into it. Each byte goes through a pulse-and-verify loop. The sequencer issues a program setup command and then the byte itself. It waits out the program interval, issues the verify command and waits out the margin interval. It then reads the byte back and compares it with the expected value. A byte that reads back wrong gets another attempt. The number of attempts per byte is bounded, and a byte that still fails at the limit ends the whole run with a failure.

The range is given by a first and a last address. The walk goes upward or downward depending on which of the two is larger, and each byte is handled entirely on its own. Expected bytes arrive one per address over a request/valid stream. The pins themselves are driven by a separate bus-cycle engine. The sequencer hands that engine one command at a time (write or read, address, write data) and waits for its done pulse; on a read, the returned byte is valid in the done cycle.

The programming supply is outside this block's control. Its readiness arrives as an input that the sequencer must see before it issues the first command of a run. Both wait intervals are counted in clock cycles, derived from a clock-frequency parameter.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, busy_o, pass_o, fail_o, bus_req_o and dat_req_o are all low.
- R2: After a start, busy_o is high and neither bus_req_o nor dat_req_o rises until vpp_ready_i has been seen high.
- R3: Each attempt on address A is exactly four bus commands in this order: write 40h to A, write the expected byte to A, write C0h to A, read A. A command's fields stay stable while bus_req_o is high until bus_done_i.
- R4: The C0h command is not requested sooner than PROG_US microseconds' worth of cycles (rounded up) after the done of the data write.
- R5: The read is not requested sooner than VERIFY_US microseconds' worth of cycles (rounded up) after the done of the C0h write.
- R6: A read value that differs from the expected byte causes another attempt on the same address. A byte that first matches on attempt k receives exactly k attempts.
- R7: A match on attempt number MAX_PULSES counts as a pass for that byte.
- R8: When the read on attempt MAX_PULSES mismatches, no further attempt is made. The sequencer writes 00h, then raises fail_o with fail_addr_o equal to the failing address. Addresses after it are not touched.
- R9: When the last address matches, the sequencer writes 00h, then raises pass_o and drops busy_o.
- R10: If first_addr_i <= last_addr_i, addresses step by +1; otherwise they step by -1. Equal addresses program one byte. No address outside the range is touched.
- R11: Exactly one expected byte is taken per address, on a cycle where dat_req_o and dat_vld_i are both high, before that address's first attempt. The same byte is written on every retry.
- R12: start_i while busy_o is high is ignored: the run in progress continues on its original range.
- R13: pass_o and fail_o are never high together, hold their value while idle, and both clear when a new run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run (taken only when idle) |
| first_addr_i | input | ADDR_W | First address of the range |
| last_addr_i | input | ADDR_W | Last address of the range |
| vpp_ready_i | input | 1 | Programming supply has reached its level |
| dat_req_o | output | 1 | Requests the expected byte for the current address |
| dat_vld_i | input | 1 | Expected byte on dat_i is valid |
| dat_i | input | 8 | Expected byte |
| bus_req_o | output | 1 | Command to the bus-cycle engine is pending |
| bus_wr_o | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr_o | output | ADDR_W | Command address |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data, valid with bus_done_i |
| bus_done_i | input | 1 | Engine completed the pending command |
| busy_o | output | 1 | A run is in progress |
| pass_o | output | 1 | Last run programmed every byte |
| fail_o | output | 1 | Last run stopped on an unprogrammable byte |
| fail_addr_o | output | ADDR_W | Address that failed |

## Verification
Two decisions can land in the same read-done cycle. The first is the attempt limit being reached. The second is the compare succeeding, possibly on the last address of the range as well. The bench provokes this with a modelled byte that needs exactly MAX_PULSES attempts. It then expects a pass with exactly that many program pulses, not a failure. A byte needing one pulse more must instead fail at that address, with the addresses behind it left at zero pulses. The flash model in the bench counts pulses per address, and the verdict, the failing address and the per-address counts are compared with values worked out from the requested needs.

// File: rtl/fps_pkg.sv
package fps_pkg;

   localparam logic [7:0] CMD_SETUP  = 8'h40;
   localparam logic [7:0] CMD_VERIFY = 8'hC0;
   localparam logic [7:0] CMD_READ   = 8'h00;

   typedef enum logic [3:0] {
      S_IDLE,
      S_VPP,
      S_FETCH,
      S_SETUP,
      S_PROG,
      S_PWAIT,
      S_VCMD,
      S_VWAIT,
      S_READ,
      S_EXIT
   } seq_state_e;

   // Microseconds to clock cycles, rounded up so no interval is shortened.
   function automatic int unsigned us_to_cycles(input longint unsigned clk_hz,
                                                input longint unsigned us);
      longint unsigned prod;
      prod = clk_hz * us + 64'd999_999;
      return 32'(prod / 64'd1_000_000);
   endfunction

endpackage

// File: rtl/fps_interval_timer.sv
module fps_interval_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             expired_o
);

   logic             run_q;
   logic [CNT_W-1:0] cnt_q;

   assign expired_o = run_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (load_i) begin
         run_q <= 1'b1;
         cnt_q <= len_i - CNT_W'(1);
      end else if (expired_o) begin
         run_q <= 1'b0;
      end else if (run_q) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   // R4/R5: a fresh interval longer than one cycle never expires at once
   a_r4_no_early_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && len_i > CNT_W'(1)) |=> !expired_o);

   // R5: expiry is a single-cycle event
   a_r5_single_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      (expired_o && !load_i) |=> !expired_o);

endmodule

// File: rtl/fps_addr_walker.sv
module fps_addr_walker #(
   parameter int ADDR_W        = 18,
   parameter bit ALLOW_DESCEND = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] first_i,
   input  logic [ADDR_W-1:0] last_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] cur_o,
   output logic              at_last_o
);

   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] last_q;
   logic              down_q;
   logic              down_d;

   generate
      if (ALLOW_DESCEND) begin : g_bidir
         assign down_d = (first_i > last_i);
      end else begin : g_upward
         assign down_d = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         last_q <= '0;
         down_q <= 1'b0;
      end else if (load_i) begin
         cur_q  <= first_i;
         last_q <= last_i;
         down_q <= down_d;
      end else if (step_i) begin
         cur_q  <= down_q ? (cur_q - ADDR_W'(1)) : (cur_q + ADDR_W'(1));
      end
   end

   assign cur_o     = cur_q;
   assign at_last_o = (cur_q == last_q);

   // R10: the controller never steps beyond the last address
   a_r10_no_step_past_last: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> !at_last_o);

   // R10: a step always moves to a different address
   a_r10_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> (cur_o != $past(cur_o)));

endmodule

// File: rtl/fps_pulse_counter.sv
module fps_pulse_counter #(
   parameter int MAXP = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic at_limit_o
);

   localparam int CW = $clog2(MAXP + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CW'(1);
      end else if (clr_i) begin
         cnt_q <= CW'(1);
      end else if (inc_i) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign at_limit_o = (cnt_q == CW'(MAXP));

   // R7: the attempt number stays within 1..MAXP
   a_r7_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q >= CW'(1)) && (cnt_q <= CW'(MAXP)));

   // R8: no retry is requested once the limit is reached
   a_r8_no_retry_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
      inc_i |-> !at_limit_o);

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
   import fps_pkg::*;
#(
   parameter int ADDR_W        = 18,
   parameter int CLK_HZ        = 125_000_000,
   parameter int PROG_US       = 10,
   parameter int VERIFY_US     = 6,
   parameter int MAX_PULSES    = 25,
   parameter bit ALLOW_DESCEND = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] first_addr_i,
   input  logic [ADDR_W-1:0] last_addr_i,
   input  logic              vpp_ready_i,
   output logic              dat_req_o,
   input  logic              dat_vld_i,
   input  logic [7:0]        dat_i,
   output logic              bus_req_o,
   output logic              bus_wr_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [7:0]        bus_wdata_o,
   input  logic [7:0]        bus_rdata_i,
   input  logic              bus_done_i,
   output logic              busy_o,
   output logic              pass_o,
   output logic              fail_o,
   output logic [ADDR_W-1:0] fail_addr_o
);

   localparam int PROG_LEN = int'(us_to_cycles(64'(CLK_HZ), 64'(PROG_US)));
   localparam int VER_LEN  = int'(us_to_cycles(64'(CLK_HZ), 64'(VERIFY_US)));
   localparam int MAX_LEN  = (PROG_LEN > VER_LEN) ? PROG_LEN : VER_LEN;
   localparam int CNT_W    = $clog2(MAX_LEN + 1);

   initial begin
      if (ADDR_W < 1 || ADDR_W > 32)      $error("ADDR_W out of range");
      if (MAX_PULSES < 1)                 $error("MAX_PULSES must be at least 1");
      if (PROG_LEN < 1 || VER_LEN < 1)    $error("wait intervals must be at least one cycle");
   end

   seq_state_e        state_q, state_d;
   logic [7:0]        exp_q;
   logic              verdict_q, verdict_d;
   logic              pass_q, fail_q;
   logic [ADDR_W-1:0] fail_addr_q;

   logic              walk_load, walk_step, walk_last;
   logic [ADDR_W-1:0] cur_addr;
   logic              pc_clr, pc_inc, pc_limit;
   logic              tmr_load, tmr_exp;
   logic [CNT_W-1:0]  tmr_len;
   logic              exp_ld, fail_cap, finish;
   logic              byte_ok;

   fps_addr_walker #(
      .ADDR_W        (ADDR_W),
      .ALLOW_DESCEND (ALLOW_DESCEND)
   ) u_walker (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (walk_load),
      .first_i   (first_addr_i),
      .last_i    (last_addr_i),
      .step_i    (walk_step),
      .cur_o     (cur_addr),
      .at_last_o (walk_last)
   );

   fps_pulse_counter #(
      .MAXP (MAX_PULSES)
   ) u_pulses (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (pc_clr),
      .inc_i      (pc_inc),
      .at_limit_o (pc_limit)
   );

   fps_interval_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (tmr_load),
      .len_i     (tmr_len),
      .expired_o (tmr_exp)
   );

   assign byte_ok = (bus_rdata_i == exp_q);

   always_comb begin
      state_d   = state_q;
      verdict_d = verdict_q;
      walk_load = 1'b0;
      walk_step = 1'b0;
      pc_clr    = 1'b0;
      pc_inc    = 1'b0;
      tmr_load  = 1'b0;
      tmr_len   = CNT_W'(PROG_LEN);
      exp_ld    = 1'b0;
      fail_cap  = 1'b0;
      finish    = 1'b0;
      case (state_q)
         S_IDLE: if (start_i) begin
            state_d   = S_VPP;
            walk_load = 1'b1;
            pc_clr    = 1'b1;
         end
         S_VPP:   if (vpp_ready_i) state_d = S_FETCH;
         S_FETCH: if (dat_vld_i) begin
            exp_ld  = 1'b1;
            state_d = S_SETUP;
         end
         S_SETUP: if (bus_done_i) state_d = S_PROG;
         S_PROG:  if (bus_done_i) begin
            state_d  = S_PWAIT;
            tmr_load = 1'b1;
            tmr_len  = CNT_W'(PROG_LEN);
         end
         S_PWAIT: if (tmr_exp) state_d = S_VCMD;
         S_VCMD:  if (bus_done_i) begin
            state_d  = S_VWAIT;
            tmr_load = 1'b1;
            tmr_len  = CNT_W'(VER_LEN);
         end
         S_VWAIT: if (tmr_exp) state_d = S_READ;
         S_READ:  if (bus_done_i) begin
            if (byte_ok) begin
               if (walk_last) begin
                  state_d   = S_EXIT;
                  verdict_d = 1'b1;
               end else begin
                  state_d   = S_FETCH;
                  walk_step = 1'b1;
                  pc_clr    = 1'b1;
               end
            end else if (pc_limit) begin
               state_d   = S_EXIT;
               verdict_d = 1'b0;
               fail_cap  = 1'b1;
            end else begin
               state_d = S_SETUP;
               pc_inc  = 1'b1;
            end
         end
         S_EXIT: if (bus_done_i) begin
            state_d = S_IDLE;
            finish  = 1'b1;
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         verdict_q   <= 1'b0;
         exp_q       <= '0;
         pass_q      <= 1'b0;
         fail_q      <= 1'b0;
         fail_addr_q <= '0;
      end else begin
         state_q   <= state_d;
         verdict_q <= verdict_d;
         if (exp_ld)    exp_q       <= dat_i;
         if (fail_cap)  fail_addr_q <= cur_addr;
         if (walk_load) begin
            pass_q <= 1'b0;
            fail_q <= 1'b0;
         end else if (finish) begin
            pass_q <= verdict_q;
            fail_q <= !verdict_q;
         end
      end
   end

   always_comb begin
      bus_req_o   = 1'b0;
      bus_wr_o    = 1'b1;
      bus_wdata_o = '0;
      case (state_q)
         S_SETUP: begin bus_req_o = 1'b1; bus_wdata_o = CMD_SETUP;  end
         S_PROG:  begin bus_req_o = 1'b1; bus_wdata_o = exp_q;      end
         S_VCMD:  begin bus_req_o = 1'b1; bus_wdata_o = CMD_VERIFY; end
         S_READ:  begin bus_req_o = 1'b1; bus_wr_o    = 1'b0;       end
         S_EXIT:  begin bus_req_o = 1'b1; bus_wdata_o = CMD_READ;   end
         default: ;
      endcase
   end

   assign bus_addr_o  = cur_addr;
   assign dat_req_o   = (state_q == S_FETCH);
   assign busy_o      = (state_q != S_IDLE);
   assign pass_o      = pass_q;
   assign fail_o      = fail_q;
   assign fail_addr_o = fail_addr_q;

   // R2: no traffic while the supply is not yet ready
   a_r2_wait_supply: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy_o) && !vpp_ready_i) |=> (!bus_req_o && !dat_req_o));

   // R3: a pending command holds its fields until the engine completes it
   a_r3_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_done_i) |=>
         (bus_req_o && $stable(bus_wr_o) && $stable(bus_addr_o) && $stable(bus_wdata_o)));

   // R8/R9: every run ends right after a completed 00h write
   a_r9_ends_with_read_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(bus_req_o && bus_done_i && bus_wr_o && bus_wdata_o == CMD_READ));

   // R11: the expected-byte request waits for valid
   a_r11_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_req_o && !dat_vld_i) |=> dat_req_o);

   // R12: a start during a run does not reload the address
   a_r12_start_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && state_q != S_READ) |=> $stable(bus_addr_o));

   // R13: the two verdicts are exclusive
   a_r13_verdict_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass_o && fail_o));

   // R13: a new run clears the verdicts
   a_r13_cleared_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> (busy_o && !pass_o && !fail_o));

endmodule

// File: tb/tb_flash_prog_seq.sv
module tb_flash_prog_seq;

   localparam int AW       = 8;
   localparam int MAXP     = 25;
   localparam int CLK_HZ   = 5_000_000;
   localparam int PROG_CYC = 50;   // 10 us at 5 MHz
   localparam int VER_CYC  = 30;   // 6 us at 5 MHz

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [AW-1:0] first_addr_i = '0;
   logic [AW-1:0] last_addr_i = '0;
   logic          vpp_ready_i = 1'b0;
   logic          dat_req_o;
   logic          dat_vld_i = 1'b0;
   logic [7:0]    dat_i = '0;
   logic          bus_req_o, bus_wr_o;
   logic [AW-1:0] bus_addr_o;
   logic [7:0]    bus_wdata_o;
   logic [7:0]    bus_rdata_i = '0;
   logic          bus_done_i = 1'b0;
   logic          busy_o, pass_o, fail_o;
   logic [AW-1:0] fail_addr_o;

   always #4 clk = ~clk;

   flash_prog_seq #(
      .ADDR_W (AW), .CLK_HZ (CLK_HZ), .PROG_US (10), .VERIFY_US (6),
      .MAX_PULSES (MAXP), .ALLOW_DESCEND (1'b1)
   ) dut (
      .clk (clk), .rst_n (rst_n), .start_i (start_i),
      .first_addr_i (first_addr_i), .last_addr_i (last_addr_i),
      .vpp_ready_i (vpp_ready_i), .dat_req_o (dat_req_o), .dat_vld_i (dat_vld_i),
      .dat_i (dat_i), .bus_req_o (bus_req_o), .bus_wr_o (bus_wr_o),
      .bus_addr_o (bus_addr_o), .bus_wdata_o (bus_wdata_o), .bus_rdata_i (bus_rdata_i),
      .bus_done_i (bus_done_i), .busy_o (busy_o), .pass_o (pass_o), .fail_o (fail_o),
      .fail_addr_o (fail_addr_o)
   );

   int n_chk = 0, n_fail = 0;
   bit ended = 0;
   logic [7:0] exp_mem [256];
   int need [256];
   int pulses [256];
   int fetched [256];
   int cyc = 0;
   int phase = 0, proto_err = 0, exit_seen = 0;
   int t_prog = 0, t_ver = 0;
   logic [AW-1:0] cur_a = '0;
   logic [AW-1:0] feed_a = '0;
   bit feed_down = 0;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic finish_up();
      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // Modelled flash plus bus-cycle engine
   task automatic accept_cmd();
      if (phase == 2 && bus_wr_o && bus_wdata_o == 8'hC0)
         check((cyc - t_prog) >= PROG_CYC && (cyc - t_prog) <= PROG_CYC + 3,
               "R4 program wait", cyc - t_prog, PROG_CYC);
      if (phase == 3 && !bus_wr_o)
         check((cyc - t_ver) >= VER_CYC && (cyc - t_ver) <= VER_CYC + 3,
               "R5 verify wait", cyc - t_ver, VER_CYC);
   endtask

   task automatic perform_cmd();
      logic [AW-1:0] a;
      a = bus_addr_o;
      case (phase)
         0: if (bus_wr_o && bus_wdata_o == 8'h40) begin cur_a = a; phase = 1; end
            else if (bus_wr_o && bus_wdata_o == 8'h00) exit_seen++;
            else proto_err++;
         1: if (bus_wr_o && a == cur_a) begin
               check(bus_wdata_o == exp_mem[a], "R11 data on retry", bus_wdata_o, exp_mem[a]);
               pulses[a]++; t_prog = cyc; phase = 2;
            end else proto_err++;
         2: if (bus_wr_o && bus_wdata_o == 8'hC0 && a == cur_a) begin t_ver = cyc; phase = 3; end
            else proto_err++;
         default: if (!bus_wr_o && a == cur_a) begin
               bus_rdata_i = (pulses[a] >= need[a]) ? exp_mem[a] : (exp_mem[a] ^ 8'h5A);
               phase = 0;
            end else proto_err++;
      endcase
   endtask

   initial begin : bus_model
      int lat;
      bit pend;
      pend = 0; lat = 0;
      forever begin
         @(negedge clk);
         cyc++;
         bus_done_i = 1'b0;
         if (!pend && bus_req_o && rst_n) begin
            pend = 1; lat = $urandom_range(0, 2); accept_cmd();
         end
         if (pend) begin
            if (lat == 0) begin perform_cmd(); bus_done_i = 1'b1; pend = 0; end
            else lat--;
         end
      end
   end

   initial begin : data_feed
      forever begin
         @(negedge clk);
         if (dat_vld_i) begin
            dat_vld_i = 1'b0;
            fetched[feed_a]++;
            feed_a = feed_down ? feed_a - 1'b1 : feed_a + 1'b1;
         end else if (dat_req_o) begin
            dat_vld_i = 1'b1;
            dat_i = exp_mem[feed_a];
         end
      end
   end

   initial begin : watchdog
      repeat (190_000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_up();
   end

   task automatic run_range(input logic [AW-1:0] f, input logic [AW-1:0] l,
                            input int vpp_delay, input bit poke);
      bit down, exp_pass, bad;
      int n, fail_at, t, outside;
      int exp_p [256];
      logic [AW-1:0] a;
      down = (f > l);
      n = down ? int'(f) - int'(l) + 1 : int'(l) - int'(f) + 1;
      exp_pass = 1; fail_at = -1;
      for (int i = 0; i < 256; i++) begin pulses[i] = 0; fetched[i] = 0; exp_p[i] = 0; end
      a = f;
      for (int i = 0; i < n; i++) begin
         if (exp_pass) begin
            if (need[a] > MAXP) begin exp_pass = 0; fail_at = int'(a); exp_p[a] = MAXP; end
            else exp_p[a] = need[a];
         end
         a = down ? a - 1'b1 : a + 1'b1;
      end
      phase = 0; proto_err = 0; exit_seen = 0;
      feed_a = f; feed_down = down;
      @(negedge clk);
      first_addr_i = f; last_addr_i = l; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o && !pass_o && !fail_o, "R13 cleared at start", {busy_o, pass_o, fail_o}, 3'b100);
      bad = 0;
      repeat (vpp_delay) begin
         @(negedge clk);
         if (bus_req_o || dat_req_o) bad = 1;
      end
      check(!bad, "R2 no traffic before supply ready", bad, 0);
      vpp_ready_i = 1'b1;
      if (poke) begin
         repeat (40) @(negedge clk);
         first_addr_i = 8'd200; last_addr_i = 8'd210; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      t = 0;
      while (!(pass_o || fail_o) && t < 60_000) begin @(negedge clk); t++; end
      check(pass_o == exp_pass, exp_pass ? "R9 pass verdict" : "R8 fail verdict", pass_o, exp_pass);
      check(fail_o == !exp_pass, "R13 verdict exclusive", fail_o, !exp_pass);
      if (!exp_pass) check(int'(fail_addr_o) == fail_at, "R8 failing address", fail_addr_o, fail_at);
      check(!busy_o && !bus_req_o, "R9 idle after verdict", {busy_o, bus_req_o}, 0);
      check(exit_seen == 1 && phase == 0, "R9 single 00h write at end", exit_seen, 1);
      check(proto_err == 0, "R3 command order", proto_err, 0);
      outside = 0;
      for (int i = 0; i < 256; i++) begin
         if (pulses[i] != exp_p[i])
            check(0, (exp_p[i] == MAXP) ? "R7 pulses at limit" : "R6 pulses per byte", pulses[i], exp_p[i]);
         else if (exp_p[i] > 0)
            check(1, "R6 pulses per byte", pulses[i], exp_p[i]);
         if (exp_p[i] > 0) check(fetched[i] == 1, "R11 one fetch per byte", fetched[i], 1);
         if (exp_p[i] == 0 && (pulses[i] != 0 || fetched[i] != 0)) outside++;
      end
      check(outside == 0, poke ? "R12 start ignored while busy" : "R10 range bounds", outside, 0);
      repeat (10) @(negedge clk);
      check(pass_o == exp_pass && fail_o == !exp_pass, "R13 verdict held", {pass_o, fail_o},
            {exp_pass, !exp_pass});
      vpp_ready_i = 1'b0;
   endtask

   initial begin : main
      int s;
      logic [AW-1:0] f, l;
      s = $urandom(32'd1234);
      for (int i = 0; i < 256; i++) begin exp_mem[i] = 8'($urandom_range(0, 255)); need[i] = 1; end
      repeat (5) @(negedge clk);
      check(!busy_o && !pass_o && !fail_o && !bus_req_o && !dat_req_o, "R1 reset state",
            {busy_o, pass_o, fail_o, bus_req_o, dat_req_o}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!busy_o && !bus_req_o && !dat_req_o, "R1 idle after reset", {busy_o, bus_req_o, dat_req_o}, 0);

      for (int i = 10; i <= 15; i++) need[i] = $urandom_range(1, 4);
      run_range(8'd10, 8'd15, 20, 0);                    // R6 R10 ascending
      for (int i = 36; i <= 40; i++) need[i] = $urandom_range(1, 3);
      run_range(8'd40, 8'd36, 5, 0);                     // R10 descending
      need[70] = 1;
      run_range(8'd70, 8'd70, 0, 0);                     // R10 single byte
      need[80] = 2; need[81] = MAXP;
      run_range(8'd80, 8'd81, 3, 0);                     // R7 match on last allowed attempt
      need[100] = 1; need[101] = MAXP + 5; need[102] = 1; need[103] = 1;
      run_range(8'd100, 8'd103, 3, 0);                   // R8 fail mid-range
      for (int i = 120; i <= 122; i++) need[i] = 2;
      run_range(8'd120, 8'd122, 2, 1);                   // R12 start while busy
      for (int k = 0; k < 4; k++) begin
         f = 8'($urandom_range(0, 250));
         l = ($urandom_range(0, 1) == 1) ? f + 8'($urandom_range(0, 4)) : f - 8'($urandom_range(0, f > 4 ? 4 : f));
         for (int i = 0; i < 256; i++) need[i] = $urandom_range(1, 3);
         if ($urandom_range(0, 3) == 0) need[l] = MAXP + 1;
         run_range(f, l, $urandom_range(0, 10), 0);
      end
      finish_up();
   end

endmodule